// File: doc/BRIEF.md
# FP32 Special-Operand Override Resolver

This unit sits next to a single-precision adder, multiplier and fused multiply-add pipeline and decides, from the operands alone, whether the arithmetic result is fixed in advance by special values: NaN operands, infinities that cancel, or an infinity multiplied by zero. When such a case applies it raises an override strobe and supplies the complete result word together with an invalid-operation request. Otherwise the strobe stays low and the main datapath result is used unchanged. Normal arithmetic, rounding, and the overflow, underflow and inexact flags belong to the datapath, not to this unit.

A runtime select picks between two NaN conventions. In the quieting convention, every NaN that leaves the unit has fraction bit 22 set, and any signaling NaN among the operands raises invalid. In the pass-through convention, NaNs leave bit for bit as they arrived and invalid is never raised. The two conventions also pick NaN operands in different orders. The invalid output is a one-cycle request to set a sticky status bit held elsewhere. It never clears that bit.

Operands are `a`, `b` and `c`. For add, sub and mul only `a` and `b` are used. For madd (a + b*c) and msub (a - b*c), `a` is the accumulator and `b`, `c` are the multiplicands. Opcode encoding: 0 add, 1 sub, 2 mul, 3 madd, 4 msub, and 5 to 7 reserved. Mode select: 0 = quieting, 1 = pass-through.

Top module: `fpsr_resolver`

## Requirements
- R1: With no NaN among the used operands, add of two infinities of opposite sign, sub of two infinities of equal sign, and mul of an infinity by a zero (in either order) give the default NaN 0x7fc00000 with override set. Invalid is 1 in quieting mode and 0 in pass-through mode.
- R2: A NaN has an all-ones exponent and a nonzero fraction, and it is signaling when fraction bit 22 is clear. In quieting mode, a NaN result has bit 22 forced to 1, and invalid is 1 exactly when any used operand is a signaling NaN.
- R3: In quieting mode, for a two-input operation where both operands are NaNs, the result is operand `b` quieted. For example, 0x7f800001 + 0x7fbfffff gives 0x7fffffff, and 0x7fbfffff + 0x7f800001 gives 0x7fc00001.
- R4: In pass-through mode, the NaN result equals the chosen operand bit for bit, with invalid 0. For two-input operations `a` wins over `b`; for example, 0x3fc00000 + 0x7f800001 gives 0x7f800001.
- R5: For madd and msub, the quieting mode picks the first NaN in the order a, c, b, and the pass-through mode picks it in the order b, c, a.
- R6: For madd and msub, when `b`×`c` is infinity times zero and `a` is a NaN, the result is `a`. It is quieted with invalid 1 in quieting mode, and returned raw with invalid 0 in pass-through mode.
- R7: For madd and msub, when `b`×`c` is infinity times zero and `a` is not a NaN, the result is the default NaN. Invalid is 1 in quieting mode and 0 in pass-through mode.
- R8: A quiet NaN operand with no signaling NaN among the used operands returns that NaN unchanged, with invalid 0, in both modes.
- R9: For madd and msub with no NaN operands, an infinite accumulator combined with an infinite product of the opposite effective sign gives the default NaN, where msub inverts the product's sign. If the signs are equal, there is no override.
- R10: When all used operands are non-NaN and no invalid combination applies, or when the opcode is reserved (5 to 7), override is 0, invalid is 0 and the result word is 0.
- R11: With registered output (the default), results appear one clock after the inputs, and an active-low asynchronous reset clears all outputs to 0.
- R12: The sign bit and the payload of a returned NaN are never altered by sub or msub. For example, quieting-mode 1.0 - 0xff800005 gives 0xffc00005.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| opnd_a_i | input | 32 | Operand a (accumulator for madd/msub) |
| opnd_b_i | input | 32 | Operand b |
| opnd_c_i | input | 32 | Operand c (madd/msub only) |
| opcode_i | input | 3 | 0 add, 1 sub, 2 mul, 3 madd, 4 msub |
| pass_mode_i | input | 1 | 0 quieting convention, 1 pass-through convention |
| ovr_valid_o | output | 1 | Result fixed by special operands |
| ovr_word_o | output | 32 | Override result word (0 when no override) |
| invalid_o | output | 1 | Request to set the sticky invalid flag |

## Verification
Two-input cases pair signaling and quiet NaNs in both operand slots, so that the two modes' opposite winners, and quieting versus raw pass-through, cannot be mistaken for each other. Three-input cases place distinct quiet-NaN payloads in each slot, singly, in pairs and all three at once, which separates the a-c-b order from the b-c-a order. Infinity-times-zero products are tried with a signaling-NaN, a quiet-NaN and a plain accumulator. Opposite-sign and same-sign infinities under add, sub, madd and msub show that the effective-sign inversion is applied to the cancellation test and never to a returned payload.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;

   // Operation codes
   localparam logic [2:0] OPC_ADD  = 3'd0;
   localparam logic [2:0] OPC_SUB  = 3'd1;
   localparam logic [2:0] OPC_MUL  = 3'd2;
   localparam logic [2:0] OPC_MADD = 3'd3;
   localparam logic [2:0] OPC_MSUB = 3'd4;

   // Per-operand classification
   typedef struct packed {
      logic sign;
      logic is_nan;
      logic is_snan;
      logic is_inf;
      logic is_zero;
   } fp_cls_t;

   // Operand index examined at a given rank of the NaN search.
   // quieting two-input: b,a ; pass two-input: a,b
   // quieting three-input: a,c,b ; pass three-input: b,c,a
   function automatic logic [1:0] pick_slot(input logic pass_mode,
                                            input logic three_in,
                                            input logic [1:0] rank);
      logic [1:0] idx;
      if (three_in) begin
         case (rank)
            2'd0:    idx = pass_mode ? 2'd1 : 2'd0;
            2'd1:    idx = 2'd2;
            default: idx = pass_mode ? 2'd0 : 2'd1;
         endcase
      end else begin
         case (rank)
            2'd0:    idx = pass_mode ? 2'd0 : 2'd1;
            2'd1:    idx = pass_mode ? 2'd1 : 2'd0;
            default: idx = 2'd2;
         endcase
      end
      return idx;
   endfunction

endpackage

// File: rtl/fpsr_classify.sv
module fpsr_classify
   import fpsr_pkg::*;
#(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23
) (
   input  logic [EXP_W+FRAC_W:0] word_i,
   output fp_cls_t               cls_o
);
   localparam int QBIT = FRAC_W - 1;

   logic [EXP_W-1:0]  expo;
   logic [FRAC_W-1:0] frac;
   logic              exp_ones;
   logic              exp_zero;
   logic              frac_zero;

   assign expo      = word_i[EXP_W+FRAC_W-1:FRAC_W];
   assign frac      = word_i[FRAC_W-1:0];
   assign exp_ones  = &expo;
   assign exp_zero  = ~|expo;
   assign frac_zero = ~|frac;

   always_comb begin
      cls_o.sign    = word_i[EXP_W+FRAC_W];
      cls_o.is_nan  = exp_ones & ~frac_zero;
      cls_o.is_snan = exp_ones & ~frac_zero & ~frac[QBIT];
      cls_o.is_inf  = exp_ones & frac_zero;
      cls_o.is_zero = exp_zero & frac_zero;
   end
endmodule

// File: rtl/fpsr_nan_pick.sv
module fpsr_nan_pick
   import fpsr_pkg::*;
#(
   parameter int WORD_W = 32
) (
   input  logic [2:0][WORD_W-1:0] opnd_i,
   input  fp_cls_t [2:0]          cls_i,
   input  logic                   three_in_i,
   input  logic                   pass_mode_i,
   output logic                   hit_o,
   output logic [WORD_W-1:0]      word_o,
   output logic                   snan_seen_o
);
   logic [2:0] used;
   logic [2:0] snan_vec;

   assign used = three_in_i ? 3'b111 : 3'b011;

   for (genvar g = 0; g < 3; g++) begin : g_snan
      assign snan_vec[g] = cls_i[g].is_snan;
   end

   assign snan_seen_o = |(used & snan_vec);

   always_comb begin
      hit_o  = 1'b0;
      word_o = '0;
      for (int r = 0; r < 3; r++) begin
         logic [1:0] idx;
         idx = pick_slot(pass_mode_i, three_in_i, 2'(r));
         if (!hit_o && used[idx] && cls_i[idx].is_nan) begin
            hit_o  = 1'b1;
            word_o = opnd_i[idx];
         end
      end
   end
endmodule

// File: rtl/fpsr_invalid_detect.sv
module fpsr_invalid_detect
   import fpsr_pkg::*;
(
   input  fp_cls_t [2:0] cls_i,
   input  logic [2:0]    opcode_i,
   output logic          prod_inv_o,
   output logic          cancel_o
);
   fp_cls_t ca, cb, cc;
   logic    prod_inf;
   logic    prod_sign;
   logic    eff_b_sign;

   assign ca = cls_i[0];
   assign cb = cls_i[1];
   assign cc = cls_i[2];

   // b*c is infinity times zero (three-input forms only)
   assign prod_inv_o = (cb.is_inf & cc.is_zero) | (cb.is_zero & cc.is_inf);

   assign prod_inf   = (cb.is_inf | cc.is_inf) & ~(cb.is_zero | cc.is_zero);
   assign prod_sign  = cb.sign ^ cc.sign ^ (opcode_i == OPC_MSUB);
   assign eff_b_sign = cb.sign ^ (opcode_i == OPC_SUB);

   always_comb begin
      case (opcode_i)
         OPC_ADD, OPC_SUB:
            cancel_o = ca.is_inf & cb.is_inf & (ca.sign != eff_b_sign);
         OPC_MUL:
            cancel_o = (ca.is_inf & cb.is_zero) | (ca.is_zero & cb.is_inf);
         OPC_MADD, OPC_MSUB:
            cancel_o = ca.is_inf & prod_inf & (ca.sign != prod_sign);
         default:
            cancel_o = 1'b0;
      endcase
   end
endmodule

// File: rtl/fpsr_resolver.sv
module fpsr_resolver
   import fpsr_pkg::*;
#(
   parameter int EXP_W   = 8,
   parameter int FRAC_W  = 23,
   parameter bit OUT_REG = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [EXP_W+FRAC_W:0]    opnd_a_i,
   input  logic [EXP_W+FRAC_W:0]    opnd_b_i,
   input  logic [EXP_W+FRAC_W:0]    opnd_c_i,
   input  logic [2:0]               opcode_i,
   input  logic                     pass_mode_i,
   output logic                     ovr_valid_o,
   output logic [EXP_W+FRAC_W:0]    ovr_word_o,
   output logic                     invalid_o
);
   localparam int WORD_W = EXP_W + FRAC_W + 1;
   localparam int QBIT   = FRAC_W - 1;
   localparam logic [WORD_W-1:0] QMASK = WORD_W'(1) << QBIT;
   localparam logic [WORD_W-1:0] DFLT_NAN =
      {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

   // Elaboration-time parameter checks
   if (EXP_W < 2) begin : g_bad_exp
      $error("fpsr_resolver: EXP_W must be at least 2");
   end
   if (FRAC_W < 2) begin : g_bad_frac
      $error("fpsr_resolver: FRAC_W must be at least 2");
   end

   logic [2:0][WORD_W-1:0] opnd;
   fp_cls_t [2:0]          cls;

   assign opnd[0] = opnd_a_i;
   assign opnd[1] = opnd_b_i;
   assign opnd[2] = opnd_c_i;

   for (genvar g = 0; g < 3; g++) begin : g_cls
      fpsr_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
         .word_i (opnd[g]),
         .cls_o  (cls[g])
      );
   end

   logic three_in;
   logic op_known;
   assign three_in = (opcode_i == OPC_MADD) || (opcode_i == OPC_MSUB);
   assign op_known = (opcode_i <= OPC_MSUB);

   logic              nan_hit;
   logic [WORD_W-1:0] nan_word;
   logic              snan_seen;

   fpsr_nan_pick #(.WORD_W(WORD_W)) u_pick (
      .opnd_i      (opnd),
      .cls_i       (cls),
      .three_in_i  (three_in),
      .pass_mode_i (pass_mode_i),
      .hit_o       (nan_hit),
      .word_o      (nan_word),
      .snan_seen_o (snan_seen)
   );

   logic prod_inv;
   logic cancel;

   fpsr_invalid_detect u_inv (
      .cls_i      (cls),
      .opcode_i   (opcode_i),
      .prod_inv_o (prod_inv),
      .cancel_o   (cancel)
   );

   logic              nxt_valid;
   logic [WORD_W-1:0] nxt_word;
   logic              nxt_inv;

   always_comb begin
      nxt_valid = 1'b0;
      nxt_word  = '0;
      nxt_inv   = 1'b0;
      if (op_known) begin
         if (three_in && prod_inv) begin
            nxt_valid = 1'b1;
            nxt_inv   = ~pass_mode_i;
            if (cls[0].is_nan)
               nxt_word = pass_mode_i ? opnd_a_i : (opnd_a_i | QMASK);
            else
               nxt_word = DFLT_NAN;
         end else if (nan_hit) begin
            nxt_valid = 1'b1;
            nxt_word  = pass_mode_i ? nan_word : (nan_word | QMASK);
            nxt_inv   = ~pass_mode_i & snan_seen;
         end else if (cancel) begin
            nxt_valid = 1'b1;
            nxt_word  = DFLT_NAN;
            nxt_inv   = ~pass_mode_i;
         end
      end
   end

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ovr_valid_o <= 1'b0;
            ovr_word_o  <= '0;
            invalid_o   <= 1'b0;
         end else begin
            ovr_valid_o <= nxt_valid;
            ovr_word_o  <= nxt_word;
            invalid_o   <= nxt_inv;
         end
      end
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk  = clk ^ rst_n;
      assign ovr_valid_o = nxt_valid;
      assign ovr_word_o  = nxt_word;
      assign invalid_o   = nxt_inv;
   end
endmodule

// File: rtl/fpsr_resolver_chk.sv
module fpsr_resolver_chk #(
   parameter int EXP_W   = 8,
   parameter int FRAC_W  = 23,
   parameter bit OUT_REG = 1'b1
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [EXP_W+FRAC_W:0] opnd_a_i,
   input logic [EXP_W+FRAC_W:0] opnd_b_i,
   input logic [EXP_W+FRAC_W:0] opnd_c_i,
   input logic [2:0]            opcode_i,
   input logic                  pass_mode_i,
   input logic                  ovr_valid_o,
   input logic [EXP_W+FRAC_W:0] ovr_word_o,
   input logic                  invalid_o
);
   localparam int QBIT = FRAC_W - 1;

   logic [EXP_W+FRAC_W:0] a_d, b_d, c_d;
   logic [2:0]            op_d;
   logic                  mode_d;

   if (OUT_REG) begin : g_dly
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            a_d <= '0; b_d <= '0; c_d <= '0; op_d <= '0; mode_d <= 1'b0;
         end else begin
            a_d <= opnd_a_i; b_d <= opnd_b_i; c_d <= opnd_c_i;
            op_d <= opcode_i; mode_d <= pass_mode_i;
         end
      end
   end else begin : g_nodly
      assign a_d = opnd_a_i;
      assign b_d = opnd_b_i;
      assign c_d = opnd_c_i;
      assign op_d = opcode_i;
      assign mode_d = pass_mode_i;
   end

   logic all_finite;
   assign all_finite = ~&a_d[EXP_W+FRAC_W-1:FRAC_W] &
                       ~&b_d[EXP_W+FRAC_W-1:FRAC_W] &
                       ~&c_d[EXP_W+FRAC_W-1:FRAC_W];

   // R10
   no_ovr_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ovr_valid_o |-> (!invalid_o && ovr_word_o == '0));

   // R4
   pass_mode_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode_d |-> !invalid_o);

   // R2
   quiet_mode_result_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_valid_o && !mode_d) |-> ovr_word_o[QBIT]);

   // R2
   ovr_is_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_valid_o |-> (&ovr_word_o[EXP_W+FRAC_W-1:FRAC_W] &&
                       |ovr_word_o[FRAC_W-1:0]));

   // R10
   reserved_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_d > 3'd4) |-> !ovr_valid_o);

   // R10
   finite_no_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      all_finite |-> !ovr_valid_o);
endmodule

bind fpsr_resolver fpsr_resolver_chk #(
   .EXP_W(EXP_W), .FRAC_W(FRAC_W), .OUT_REG(OUT_REG)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .opnd_a_i    (opnd_a_i),
   .opnd_b_i    (opnd_b_i),
   .opnd_c_i    (opnd_c_i),
   .opcode_i    (opcode_i),
   .pass_mode_i (pass_mode_i),
   .ovr_valid_o (ovr_valid_o),
   .ovr_word_o  (ovr_word_o),
   .invalid_o   (invalid_o)
);

// File: tb/fpsr_resolver_bench.sv
module fpsr_resolver_bench;
   localparam logic [31:0] DNAN = 32'h7fc00000;
   localparam logic [31:0] PINF = 32'h7f800000;
   localparam logic [31:0] NINF = 32'hff800000;
   localparam logic [31:0] ONE  = 32'h3f800000;
   localparam logic [31:0] ONE5 = 32'h3fc00000;
   localparam logic [31:0] ZERO = 32'h00000000;
   localparam logic [2:0] ADD = 3'd0, SUB = 3'd1, MUL = 3'd2, MADD = 3'd3, MSUB = 3'd4;
   localparam logic QM = 1'b0, PM = 1'b1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] a = '0, b = '0, c = '0;
   logic [2:0]  op = '0;
   logic        mode = 1'b0;
   logic        ovr_v;
   logic [31:0] ovr_w;
   logic        inv;

   int n_chk = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   fpsr_resolver u_fpsr_resolver (
      .clk(clk), .rst_n(rst_n),
      .opnd_a_i(a), .opnd_b_i(b), .opnd_c_i(c),
      .opcode_i(op), .pass_mode_i(mode),
      .ovr_valid_o(ovr_v), .ovr_word_o(ovr_w), .invalid_o(inv)
   );

   task automatic compare(input string tag, input logic ev, input logic [31:0] ew,
                          input logic ei);
      n_chk++;
      if (ovr_v !== ev || ovr_w !== ew || inv !== ei) begin
         n_fail++;
         $display("FAIL %s: got v=%0b w=%h inv=%0b expected v=%0b w=%h inv=%0b",
                  tag, ovr_v, ovr_w, inv, ev, ew, ei);
      end
   endtask

   // drive at a falling edge, result registered at next rising edge,
   // sampled at the following falling edge
   task automatic run(input string tag, input logic [31:0] ia, input logic [31:0] ib,
                      input logic [31:0] ic, input logic [2:0] iop, input logic im,
                      input logic ev, input logic [31:0] ew, input logic ei);
      @(negedge clk);
      a = ia; b = ib; c = ic; op = iop; mode = im;
      @(negedge clk);
      compare(tag, ev, ew, ei);
   endtask

   task automatic t_reset;
      #1 compare("R11 reset state", 1'b0, 32'h0, 1'b0);
   endtask

   task automatic t_default_nan;
      run("R1 +inf + -inf quiet", PINF, NINF, ZERO, ADD, QM, 1'b1, DNAN, 1'b1);
      run("R1 +inf + -inf pass",  PINF, NINF, ZERO, ADD, PM, 1'b1, DNAN, 1'b0);
      run("R1 inf - inf quiet",   PINF, PINF, ZERO, SUB, QM, 1'b1, DNAN, 1'b1);
      run("R1 0 * inf quiet",     ZERO, PINF, ZERO, MUL, QM, 1'b1, DNAN, 1'b1);
      run("R1 inf * 0 pass",      PINF, ZERO, ZERO, MUL, PM, 1'b1, DNAN, 1'b0);
      run("R1 inf + inf no ovr",  PINF, PINF, ZERO, ADD, QM, 1'b0, 32'h0, 1'b0);
   endtask

   task automatic t_quiet_two;
      run("R3 snan+snan b wins", 32'h7f800001, 32'h7fbfffff, ZERO, ADD, QM, 1'b1, 32'h7fffffff, 1'b1);
      run("R3 snan+snan swap",   32'h7fbfffff, 32'h7f800001, ZERO, ADD, QM, 1'b1, 32'h7fc00001, 1'b1);
      run("R2 1.5+snan quieted", ONE5, 32'h7f800001, ZERO, ADD, QM, 1'b1, 32'h7fc00001, 1'b1);
      run("R2 qnan+snan",        32'h7fc00001, 32'h7fbfffff, ZERO, ADD, QM, 1'b1, 32'h7fffffff, 1'b1);
      run("R3 snan+qnan",        32'h7fbfffff, 32'h7fc00001, ZERO, MUL, QM, 1'b1, 32'h7fc00001, 1'b1);
      run("R2 unused c snan",    ONE, 32'h7fc00002, 32'h7f800001, ADD, QM, 1'b1, 32'h7fc00002, 1'b0);
   endtask

   task automatic t_pass_two;
      run("R4 1.5+snan raw",  ONE5, 32'h7f800001, ZERO, ADD, PM, 1'b1, 32'h7f800001, 1'b0);
      run("R4 snan+snan a",   32'h7f800001, 32'h7fbfffff, ZERO, ADD, PM, 1'b1, 32'h7f800001, 1'b0);
      run("R4 snan+snan a2",  32'h7fbfffff, 32'h7f800001, ZERO, SUB, PM, 1'b1, 32'h7fbfffff, 1'b0);
      run("R4 qnan*snan a",   32'h7fc00001, 32'h7fbfffff, ZERO, MUL, PM, 1'b1, 32'h7fc00001, 1'b0);
   endtask

   task automatic t_madd_order;
      run("R5 q a only",     32'h7fc00001, ONE, ONE, MADD, QM, 1'b1, 32'h7fc00001, 1'b0);
      run("R5 q b only",     ONE, 32'h7fc00002, ONE, MADD, PM, 1'b1, 32'h7fc00002, 1'b0);
      run("R5 q c only",     ONE, ONE, 32'h7fc00003, MSUB, QM, 1'b1, 32'h7fc00003, 1'b0);
      run("R5 ab quiet",     32'h7fc00001, 32'h7fc00002, ONE, MADD, QM, 1'b1, 32'h7fc00001, 1'b0);
      run("R5 ab pass",      32'h7fc00001, 32'h7fc00002, ONE, MADD, PM, 1'b1, 32'h7fc00002, 1'b0);
      run("R5 ac quiet",     32'h7fc00001, ONE, 32'h7fc00003, MADD, QM, 1'b1, 32'h7fc00001, 1'b0);
      run("R5 ac pass",      32'h7fc00001, ONE, 32'h7fc00003, MADD, PM, 1'b1, 32'h7fc00003, 1'b0);
      run("R5 bc quiet",     ONE, 32'h7fc00002, 32'h7fc00003, MADD, QM, 1'b1, 32'h7fc00003, 1'b0);
      run("R5 bc pass",      ONE, 32'h7fc00002, 32'h7fc00003, MADD, PM, 1'b1, 32'h7fc00002, 1'b0);
      run("R5 abc quiet",    32'h7fc00001, 32'h7fc00002, 32'h7fc00003, MADD, QM, 1'b1, 32'h7fc00001, 1'b0);
      run("R5 abc pass",     32'h7fc00001, 32'h7fc00002, 32'h7fc00003, MSUB, PM, 1'b1, 32'h7fc00002, 1'b0);
      run("R5 q a, s b quiet", 32'h7fc00001, 32'h7f800002, ONE, MADD, QM, 1'b1, 32'h7fc00001, 1'b1);
      run("R5 q a, s b pass",  32'h7fc00001, 32'h7f800002, ONE, MADD, PM, 1'b1, 32'h7f800002, 1'b0);
      run("R2 s a quiet",      32'h7f800001, ONE, ONE, MADD, QM, 1'b1, 32'h7fc00001, 1'b1);
   endtask

   task automatic t_prod_invalid;
      run("R6 snan acc quiet", 32'h7f800001, PINF, ZERO, MADD, QM, 1'b1, 32'h7fc00001, 1'b1);
      run("R6 snan acc pass",  32'h7f800001, PINF, ZERO, MADD, PM, 1'b1, 32'h7f800001, 1'b0);
      run("R6 qnan acc quiet", 32'h7fc00001, ZERO, PINF, MSUB, QM, 1'b1, 32'h7fc00001, 1'b1);
      run("R7 plain acc quiet", ONE, PINF, ZERO, MADD, QM, 1'b1, DNAN, 1'b1);
      run("R7 plain acc pass",  ONE, PINF, ZERO, MSUB, PM, 1'b1, DNAN, 1'b0);
   endtask

   task automatic t_qnan_plain;
      run("R8 1.5+qnan quiet", ONE5, 32'h7fc00001, ZERO, ADD, QM, 1'b1, 32'h7fc00001, 1'b0);
      run("R8 1.5+qnan pass",  ONE5, 32'h7fc00001, ZERO, ADD, PM, 1'b1, 32'h7fc00001, 1'b0);
   endtask

   task automatic t_madd_cancel;
      run("R9 -inf + inf*1",  NINF, PINF, ONE, MADD, QM, 1'b1, DNAN, 1'b1);
      run("R9 inf - inf*1",   PINF, PINF, ONE, MSUB, QM, 1'b1, DNAN, 1'b1);
      run("R9 inf + inf*1",   PINF, PINF, ONE, MADD, QM, 1'b0, 32'h0, 1'b0);
      run("R9 inf - (-inf)*1", PINF, NINF, ONE, MSUB, PM, 1'b0, 32'h0, 1'b0);
   endtask

   task automatic t_no_override;
      run("R10 finite add",   ONE, ONE, ZERO, ADD, QM, 1'b0, 32'h0, 1'b0);
      run("R10 finite madd",  ONE, ONE5, ONE, MADD, PM, 1'b0, 32'h0, 1'b0);
      run("R10 reserved op",  32'h7f800001, PINF, ZERO, 3'd5, QM, 1'b0, 32'h0, 1'b0);
      run("R10 reserved op7", NINF, PINF, ZERO, 3'd7, QM, 1'b0, 32'h0, 1'b0);
   endtask

   task automatic t_sign_keep;
      run("R12 sub neg qnan", ONE, 32'hffc00005, ZERO, SUB, QM, 1'b1, 32'hffc00005, 1'b0);
      run("R12 sub neg snan", ONE, 32'hff800005, ZERO, SUB, QM, 1'b1, 32'hffc00005, 1'b1);
      run("R12 msub neg nan", ONE, 32'hff800007, ONE, MSUB, PM, 1'b1, 32'hff800007, 1'b0);
   endtask

   task automatic t_latency;
      run("R11 latency setup", PINF, NINF, ZERO, ADD, QM, 1'b1, DNAN, 1'b1);
      @(negedge clk);
      a = ONE; b = ONE; op = ADD;
      #1 compare("R11 output held before edge", 1'b1, DNAN, 1'b1);
      @(negedge clk);
      compare("R11 output after one edge", 1'b0, 32'h0, 1'b0);
      a = PINF; b = NINF;
      @(negedge clk);
      rst_n = 1'b0;
      #1 compare("R11 async reset clears", 1'b0, 32'h0, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_default_nan();
      t_quiet_two();
      t_pass_two();
      t_madd_order();
      t_prod_invalid();
      t_qnan_plain();
      t_madd_cancel();
      t_no_override();
      t_sign_keep();
      t_latency();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #2000000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, got hang expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule